// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block produces three complementary pairs of switching signals, one high-side and one low-side per phase, for a three-phase inverter. A triangular time base counts up and then back down over each switching period. Each phase compares the count against its duty value to give a pulse centred on the middle of the period. A programmable dead band trims both edges so that the two switches of one leg are never on together. Duty, half-period and dead-time values are written into shadow copies. The time base moves them into the working set only at its turning points: once per period in single-update mode, and at both the start and the middle in double-update mode.

A sync strobe of programmable width marks every load point for the surrounding control loop. A free-running carrier can chop the active state of the high-side outputs, the low-side outputs, or both, with one enable for each side. A trip input and twelve general-purpose pins, each admitted through its own mask bit, force all six outputs inactive at once, without waiting for a clock edge, and set a latched shutdown. The latch leaves reset set, so nothing switches until software clears it.

Top module: `tri_pwm_gen`

## Requirements
- R1: After reset, the shutdown latch is set (`shut_o` = 1) and all six outputs stay low until a write to the control register (address 0x6) with bit 3 set clears the latch.
- R2: With half-period H (address 0x0, values below 2 act as 2), duty D (addresses 0x1/0x2/0x3 for phases 0/1/2) and dead time T (address 0x4), where 0 < D < H, each switching period lasts 2H cycles. In that period the high side is on for 2·max(D−T,0) cycles and the low side for 2·max(H−D−T,0) cycles, with the same count in the rising and the falling half.
- R3: A duty of 0 holds the high side off and the low side on for the whole period. A duty of H or more holds the high side on and the low side off, and the dead time is not applied in either case.
- R4: The high-side and low-side outputs of one phase are never active in the same cycle.
- R5: In single-update mode (control bit 0 = 0), writes to the half-period, duty and dead-time registers have no effect on the period already running. They take effect from the next period start.
- R6: In double-update mode (control bit 0 = 1), the shadow values are also loaded at the midpoint, so a write takes effect in the next half. The sync strobe then starts every H cycles.
- R7: In single-update mode the sync strobe rises once every 2H cycles and stays high for the width held at address 0x5 (0 acts as 1).
- R8: Control bit 1 gates the high-side active state, and control bit 2 the low-side active state, with a carrier whose high and low intervals each last C+1 cycles (C at address 0x7). The enable for one side leaves the other side unchanged.
- R9: A high `trip_i` forces all six outputs low in the same cycle and sets the latch. `trip_lvl_o` shows the trip level one clock later.
- R10: Pin i of `pins_i` acts as a shutdown source only when bit i of the mask at address 0x8 is set. An unmasked pin has no effect.
- R11: The latch stays set while any shutdown source is active, even when a clear is written. Once the sources are gone, a clear write releases it and switching resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | W | Register write data |
| trip_i | input | 1 | Trip input, active high |
| pins_i | input | NPIN | General-purpose pins usable as shutdown sources |
| pwm_hi_o | output | 3 | High-side drive, one bit per phase, active high |
| pwm_lo_o | output | 3 | Low-side drive, one bit per phase, active high |
| sync_o | output | 1 | Sync strobe at load points |
| trip_lvl_o | output | 1 | Registered level of the trip input |
| shut_o | output | 1 | Shutdown latch state |

## Verification
The bench builds the block with a 12-bit data path, twelve shutdown pins and a reset half-period of 16. This keeps switching periods to a few dozen cycles, so many full periods, both update modes and every shutdown path fit in a short run. On-time counts are taken over windows aligned to the sync strobe. Randomised half-periods, duties past the clamp limit and dead times that swallow whole pulses are compared with closed-form expected counts. Directed cases place writes just after a load point, to show where the single and double update modes differ.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  localparam int unsigned NPH = 3;

  localparam logic [3:0] ADR_HALF  = 4'h0;
  localparam logic [3:0] ADR_DUTY0 = 4'h1;
  localparam logic [3:0] ADR_DEAD  = 4'h4;
  localparam logic [3:0] ADR_SYNCW = 4'h5;
  localparam logic [3:0] ADR_CTRL  = 4'h6;
  localparam logic [3:0] ADR_CHOP  = 4'h7;
  localparam logic [3:0] ADR_PMASK = 4'h8;

  localparam int CTRL_DBL   = 0;
  localparam int CTRL_CHOPH = 1;
  localparam int CTRL_CHOPL = 2;
  localparam int CTRL_CLR   = 3;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;

  // Half-period actually used by the time base.
  function automatic logic [31:0] eff_half(input logic [31:0] h);
    return (h < 32'd2) ? 32'd2 : h;
  endfunction

  // High side on for count values at or above threshold plus dead band.
  function automatic logic hi_on(input logic [31:0] cnt, input logic [31:0] half,
                                 input logic [31:0] duty, input logic [31:0] dead);
    if (duty == 32'd0) return 1'b0;
    if (duty >= half)  return 1'b1;
    return cnt >= (half - duty) + dead;
  endfunction

  // Low side on for count values below threshold minus dead band.
  function automatic logic lo_on(input logic [31:0] cnt, input logic [31:0] half,
                                 input logic [31:0] duty, input logic [31:0] dead);
    if (duty == 32'd0) return 1'b1;
    if (duty >= half)  return 1'b0;
    return (cnt + dead) < (half - duty);
  endfunction

endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int W        = 16,
  parameter int NPIN     = 12,
  parameter int HALF_RST = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [3:0]            wr_addr,
  input  logic [W-1:0]          wr_data,
  input  logic                  load_i,
  output logic [W-1:0]          half_act_o,
  output logic [NPH-1:0][W-1:0] duty_act_o,
  output logic [W-1:0]          dead_act_o,
  output logic [W-1:0]          syncw_o,
  output logic [W-1:0]          chop_div_o,
  output logic [NPIN-1:0]       pmask_o,
  output logic                  dbl_o,
  output logic                  chop_h_o,
  output logic                  chop_l_o,
  output logic                  clr_req_o
);

  logic [W-1:0]          half_sh;
  logic [NPH-1:0][W-1:0] duty_sh;
  logic [W-1:0]          dead_sh;
  logic [2:0]            ctrl_q;

  assign clr_req_o = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTRL_CLR];
  assign dbl_o     = ctrl_q[CTRL_DBL];
  assign chop_h_o  = ctrl_q[CTRL_CHOPH];
  assign chop_l_o  = ctrl_q[CTRL_CHOPL];

  // Shadow and direct registers written by the port.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_sh    <= W'(HALF_RST);
      duty_sh    <= '0;
      dead_sh    <= '0;
      syncw_o    <= W'(1);
      chop_div_o <= '0;
      pmask_o    <= '0;
      ctrl_q     <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_HALF)  half_sh    <= wr_data;
      if (wr_addr == ADR_DEAD)  dead_sh    <= wr_data;
      if (wr_addr == ADR_SYNCW) syncw_o    <= wr_data;
      if (wr_addr == ADR_CHOP)  chop_div_o <= wr_data;
      if (wr_addr == ADR_PMASK) pmask_o    <= wr_data[NPIN-1:0];
      if (wr_addr == ADR_CTRL)  ctrl_q     <= wr_data[2:0];
      for (int i = 0; i < NPH; i++) begin
        if (wr_addr == ADR_DUTY0 + 4'(i)) duty_sh[i] <= wr_data;
      end
    end
  end

  // Working set, refreshed only at the turning points named by load_i.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_act_o <= W'(HALF_RST);
      duty_act_o <= '0;
      dead_act_o <= '0;
    end else if (load_i) begin
      half_act_o <= half_sh;
      duty_act_o <= duty_sh;
      dead_act_o <= dead_sh;
    end
  end

  // R5: working values never move between load points.
  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(duty_act_o) && $stable(half_act_o) && $stable(dead_act_o)));

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] half_act_i,
  input  logic         dbl_i,
  input  logic [W-1:0] syncw_i,
  input  logic [W-1:0] chop_div_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] half_eff_o,
  output logic         load_o,
  output logic         sync_o,
  output logic         chop_car_o
);

  dir_e         dir_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] chop_q;
  logic         car_q;
  logic         ev_start;
  logic         ev_mid;

  assign half_eff_o = W'(eff_half(32'(half_act_i)));
  assign ev_start   = (dir_q == DIR_DOWN) && (cnt_q == '0);
  assign ev_mid     = (dir_q == DIR_UP) && (cnt_q == half_eff_o - W'(1));
  assign load_o     = ev_start || (ev_mid && dbl_i);
  assign cnt_o      = cnt_q;
  assign sync_o     = (sync_q != '0);
  assign chop_car_o = car_q;

  // Triangle counter: turning points repeat their end value for one cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= DIR_DOWN;
      cnt_q <= '0;
    end else if (ev_start) begin
      dir_q <= DIR_UP;
    end else if (ev_mid) begin
      dir_q <= DIR_DOWN;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + W'(1);
    end else begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  // Sync strobe: width counter started at every load point.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else if (load_o) begin
      sync_q <= (syncw_i == '0) ? W'(1) : syncw_i;
    end else if (sync_q != '0) begin
      sync_q <= sync_q - W'(1);
    end
  end

  // Chopping carrier: each level held chop_div_i + 1 cycles.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chop_q <= '0;
      car_q  <= 1'b1;
    end else if (chop_q >= chop_div_i) begin
      chop_q <= '0;
      car_q  <= ~car_q;
    end else begin
      chop_q <= chop_q + W'(1);
    end
  end

  // R2: rising half never runs past the working half-period.
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == DIR_UP) |-> (cnt_q < half_eff_o));

  // R6: every load point is followed by a sync strobe.
  p_sync_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> sync_o);

  // R7: in single-update mode a midpoint never loads.
  p_no_mid_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_i && (dir_q == DIR_UP)) |-> !load_o);

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
  import pwm3_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] half_eff_i,
  input  logic [W-1:0] duty_i,
  input  logic [W-1:0] dead_i,
  input  logic         car_i,
  input  logic         chop_h_i,
  input  logic         chop_l_i,
  output logic         hi_o,
  output logic         lo_o
);

  logic hi_raw;
  logic lo_raw;
  logic hi_d;
  logic lo_d;

  assign hi_raw = hi_on(32'(cnt_i), 32'(half_eff_i), 32'(duty_i), 32'(dead_i));
  assign lo_raw = lo_on(32'(cnt_i), 32'(half_eff_i), 32'(duty_i), 32'(dead_i));
  assign hi_d   = hi_raw && (car_i || !chop_h_i);
  assign lo_d   = lo_raw && (car_i || !chop_l_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
    end else begin
      hi_o <= hi_d;
      lo_o <= lo_d;
    end
  end

  // R4: the two switches of one leg are never on together.
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_o && lo_o));

endmodule

// File: rtl/pwm3_guard.sv
module pwm3_guard #(
  parameter int NPIN = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trip_i,
  input  logic [NPIN-1:0] pins_i,
  input  logic [NPIN-1:0] pmask_i,
  input  logic            clr_req_i,
  output logic            kill_o,
  output logic            shut_o,
  output logic            trip_lvl_o
);

  logic src_any;

  assign src_any = trip_i || ((pins_i & pmask_i) != '0);
  assign kill_o  = shut_o || src_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shut_o     <= 1'b1;
      trip_lvl_o <= 1'b0;
    end else begin
      trip_lvl_o <= trip_i;
      if (src_any)        shut_o <= 1'b1;
      else if (clr_req_i) shut_o <= 1'b0;
    end
  end

  // R11: an active source leaves the latch set whatever is written.
  p_clear_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    src_any |=> shut_o);

  // R11: without a clear request the latch holds.
  p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_o && !clr_req_i) |=> shut_o);

endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen
  import pwm3_pkg::*;
#(
  parameter int W        = 16,
  parameter int NPIN     = 12,
  parameter int HALF_RST = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            trip_i,
  input  logic [NPIN-1:0] pins_i,
  output logic [2:0]      pwm_hi_o,
  output logic [2:0]      pwm_lo_o,
  output logic            sync_o,
  output logic            trip_lvl_o,
  output logic            shut_o
);

  logic [W-1:0]          half_act;
  logic [W-1:0]          half_eff;
  logic [NPH-1:0][W-1:0] duty_act;
  logic [W-1:0]          dead_act;
  logic [W-1:0]          syncw;
  logic [W-1:0]          chop_div;
  logic [NPIN-1:0]       pmask;
  logic                  dbl;
  logic                  chop_h;
  logic                  chop_l;
  logic                  clr_req;
  logic                  load;
  logic [W-1:0]          cnt;
  logic                  car;
  logic                  kill;
  logic [NPH-1:0]        hi_q;
  logic [NPH-1:0]        lo_q;

  pwm3_regs #(.W(W), .NPIN(NPIN), .HALF_RST(HALF_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_i(load), .half_act_o(half_act), .duty_act_o(duty_act), .dead_act_o(dead_act),
    .syncw_o(syncw), .chop_div_o(chop_div), .pmask_o(pmask), .dbl_o(dbl),
    .chop_h_o(chop_h), .chop_l_o(chop_l), .clr_req_o(clr_req)
  );

  pwm3_timebase #(.W(W)) tb_i (
    .clk(clk), .rst_n(rst_n), .half_act_i(half_act), .dbl_i(dbl), .syncw_i(syncw),
    .chop_div_i(chop_div), .cnt_o(cnt), .half_eff_o(half_eff), .load_o(load),
    .sync_o(sync_o), .chop_car_o(car)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    pwm3_phase #(.W(W)) ph_i (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .half_eff_i(half_eff),
      .duty_i(duty_act[g]), .dead_i(dead_act), .car_i(car),
      .chop_h_i(chop_h), .chop_l_i(chop_l), .hi_o(hi_q[g]), .lo_o(lo_q[g])
    );
  end

  pwm3_guard #(.NPIN(NPIN)) guard_i (
    .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .pins_i(pins_i), .pmask_i(pmask),
    .clr_req_i(clr_req), .kill_o(kill), .shut_o(shut_o), .trip_lvl_o(trip_lvl_o)
  );

  // Shutdown gating acts without a clock edge.
  assign pwm_hi_o = kill ? '0 : hi_q;
  assign pwm_lo_o = kill ? '0 : lo_q;

  // R9: a high trip input leaves every output inactive.
  p_trip_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |-> ((pwm_hi_o == 3'b000) && (pwm_lo_o == 3'b000)));

  // R1: while latched off nothing switches.
  p_latched_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shut_o |-> ((pwm_hi_o == 3'b000) && (pwm_lo_o == 3'b000)));

endmodule

// File: tb/tri_pwm_gen_tb_top.sv
module tri_pwm_gen_tb_top;

  localparam int W    = 12;
  localparam int NPIN = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_addr = '0;
  logic [W-1:0]    wr_data = '0;
  logic            trip_i = 1'b0;
  logic [NPIN-1:0] pins_i = '0;
  logic [2:0]      pwm_hi;
  logic [2:0]      pwm_lo;
  logic            sync_o;
  logic            trip_lvl;
  logic            shut;

  int nchk = 0;
  int nerr = 0;
  int mh[3];
  int ml[3];

  always #2 clk = ~clk;

  tri_pwm_gen #(.W(W), .NPIN(NPIN), .HALF_RST(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trip_i(trip_i), .pins_i(pins_i), .pwm_hi_o(pwm_hi), .pwm_lo_o(pwm_lo),
    .sync_o(sync_o), .trip_lvl_o(trip_lvl), .shut_o(shut)
  );

  function automatic int exp_hi(int p, int d, int dt);
    if (d == 0) return 0;
    if (d >= p) return 2 * p;
    return (d > dt) ? 2 * (d - dt) : 0;
  endfunction

  function automatic int exp_lo(int p, int d, int dt);
    if (d == 0) return 2 * p;
    if (d >= p) return 0;
    return (p - d > dt) ? 2 * (p - d - dt) : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int p, input int d0, input int d1, input int d2, input int dt);
    wr(4'h0, p); wr(4'h1, d0); wr(4'h2, d1); wr(4'h3, d2); wr(4'h4, dt);
  endtask

  task automatic wait_sync_rise();
    logic pv;
    pv = sync_o;
    forever begin
      @(negedge clk);
      if (sync_o && !pv) break;
      pv = sync_o;
    end
  endtask

  task automatic measure(input int n);
    for (int k = 0; k < 3; k++) begin mh[k] = 0; ml[k] = 0; end
    repeat (n) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        mh[k] += int'(pwm_hi[k]);
        ml[k] += int'(pwm_lo[k]);
      end
    end
  endtask

  task automatic sync_shape(output int w, output int gap);
    logic pv;
    bit inp;
    wait_sync_rise();
    w = 1; gap = 0; inp = 1; pv = 1'b1;
    forever begin
      @(negedge clk);
      gap++;
      if (sync_o && !pv) break;
      if (inp && sync_o) w++; else inp = 0;
      pv = sync_o;
    end
  endtask

  task automatic check_period(input string tag, input int p, input int d0, input int d1,
                              input int d2, input int dt);
    int dd[3];
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    wait_sync_rise();
    measure(2 * p);
    for (int k = 0; k < 3; k++) begin
      chk(mh[k] == exp_hi(p, dd[k], dt), {tag, " hi"}, mh[k], exp_hi(p, dd[k], dt));
      chk(ml[k] == exp_lo(p, dd[k], dt), {tag, " lo"}, ml[k], exp_lo(p, dd[k], dt));
    end
  endtask

  // Watchdog: an expired run counts as a failed check.
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int w, gap, run, maxrun, seen0, bad;
    int p, d0, d1, d2, dt;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: latched off out of reset.
    chk(shut == 1'b1, "R1 shut after reset", int'(shut), 1);
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (pwm_hi != 3'b000 || pwm_lo != 3'b000) bad++;
    end
    chk(bad == 0, "R1 outputs low until clear", bad, 0);
    wr(4'h6, 8);
    chk(shut == 1'b0, "R1 clear releases", int'(shut), 0);
    check_period("R1 reset values", 16, 0, 0, 0, 0);

    // R2: mid-range duties.
    cfg(20, 5, 10, 15, 2);
    check_period("R2 mid duties", 20, 5, 10, 15, 2);
    // R2: dead band swallowing pulses.
    cfg(12, 2, 9, 6, 3);
    check_period("R2 dead band", 12, 2, 9, 6, 3);
    // R3: clamp cases.
    cfg(14, 0, 14, 21, 3);
    check_period("R3 clamp", 14, 0, 14, 21, 3);
    // R3: half-period below 2 acts as 2.
    cfg(1, 1, 0, 2, 0);
    check_period("R3 tiny half", 2, 1, 0, 2, 0);

    // R2 R3: random configurations, single-update mode.
    for (int it = 0; it < 10; it++) begin
      p  = 8 + int'($urandom % 33);
      d0 = int'($urandom % (p + 4));
      d1 = int'($urandom % (p + 4));
      d2 = int'($urandom % (p + 4));
      dt = int'($urandom % 5);
      cfg(p, d0, d1, d2, dt);
      check_period("R2 random", p, d0, d1, d2, dt);
    end

    // R5: a write just after a period start waits for the next start.
    cfg(20, 5, 10, 15, 2);
    wait_sync_rise();
    wait_sync_rise();
    fork
      measure(20);
      wr(4'h1, 12);
    join
    chk(mh[0] == 3, "R5 first half old", mh[0], 3);
    measure(20);
    chk(mh[0] == 3, "R5 second half old", mh[0], 3);
    check_period("R5 next period new", 20, 12, 10, 15, 2);

    // R7: sync once per period with programmed width.
    wr(4'h5, 4);
    sync_shape(w, gap);
    chk(w == 4, "R7 sync width", w, 4);
    chk(gap == 40, "R7 sync spacing", gap, 40);
    wr(4'h5, 0);
    sync_shape(w, gap);
    chk(w == 1, "R7 zero width acts as one", w, 1);

    // R6: double update, midpoint load and doubled sync rate.
    wr(4'h5, 3);
    wr(4'h6, 1);
    sync_shape(w, gap);
    chk(w == 3, "R6 sync width", w, 3);
    chk(gap == 20, "R6 sync spacing", gap, 20);
    wait_sync_rise();
    fork
      measure(20);
      wr(4'h1, 7);
    join
    chk(mh[0] == 10, "R6 current half old", mh[0], 10);
    measure(20);
    chk(mh[0] == 5, "R6 next half new", mh[0], 5);
    wr(4'h6, 0);
    wr(4'h5, 1);

    // R8: high-side chopping with duty at full on.
    cfg(16, 16, 16, 16, 0);
    wr(4'h7, 3);
    wait_sync_rise();
    wait_sync_rise();
    wr(4'h6, 2);
    maxrun = 0; run = 0; seen0 = 0; bad = 0;
    repeat (120) begin
      @(negedge clk);
      if (pwm_hi[0]) begin run++; if (run > maxrun) maxrun = run; end
      else begin run = 0; seen0++; end
      if (pwm_lo != 3'b000) bad++;
    end
    chk(maxrun == 4, "R8 high chop run", maxrun, 4);
    chk(seen0 > 0, "R8 high chop gaps", seen0, 1);
    chk(bad == 0, "R8 low side untouched", bad, 0);
    // R8: low-side enable alone, high-side enable left on a held-off side.
    cfg(16, 0, 0, 0, 0);
    wr(4'h6, 2);
    wait_sync_rise();
    wait_sync_rise();
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (pwm_lo != 3'b111) bad++;
    end
    chk(bad == 0, "R8 high enable leaves low side", bad, 0);
    wr(4'h6, 4);
    maxrun = 0; run = 0; seen0 = 0;
    repeat (120) begin
      @(negedge clk);
      if (pwm_lo[1]) begin run++; if (run > maxrun) maxrun = run; end
      else begin run = 0; seen0++; end
    end
    chk(maxrun == 4, "R8 low chop run", maxrun, 4);
    chk(seen0 > 0, "R8 low chop gaps", seen0, 1);
    wr(4'h6, 0);

    // R9: trip forces outputs low at once.
    cfg(20, 10, 10, 10, 1);
    check_period("R9 before trip", 20, 10, 10, 10, 1);
    @(negedge clk);
    trip_i = 1'b1;
    #1;
    chk(pwm_hi == 3'b000 && pwm_lo == 3'b000, "R9 immediate off",
        int'({pwm_hi, pwm_lo}), 0);
    @(negedge clk);
    chk(trip_lvl == 1'b1, "R9 trip level", int'(trip_lvl), 1);
    chk(shut == 1'b1, "R9 latch set", int'(shut), 1);
    // R11: clear while trip still high is refused.
    wr(4'h6, 8);
    trip_i = 1'b0;
    measure(40);
    chk(ml[0] + mh[0] + ml[2] == 0, "R11 still latched", ml[0] + mh[0] + ml[2], 0);
    chk(trip_lvl == 1'b0, "R9 trip level low", int'(trip_lvl), 0);
    wr(4'h6, 8);
    chk(shut == 1'b0, "R11 clear after release", int'(shut), 0);
    check_period("R11 resumed", 20, 10, 10, 10, 1);

    // R10: unmasked pin ignored, masked pin shuts down.
    wr(4'h8, 12'h008);
    @(negedge clk);
    pins_i[5] = 1'b1;
    repeat (3) @(negedge clk);
    pins_i[5] = 1'b0;
    chk(shut == 1'b0, "R10 unmasked pin ignored", int'(shut), 0);
    check_period("R10 unmasked keeps switching", 20, 10, 10, 10, 1);
    @(negedge clk);
    pins_i[3] = 1'b1;
    #1;
    chk(pwm_hi == 3'b000 && pwm_lo == 3'b000, "R10 masked pin off",
        int'({pwm_hi, pwm_lo}), 0);
    repeat (2) @(negedge clk);
    pins_i[3] = 1'b0;
    measure(40);
    chk(ml[1] + mh[1] == 0, "R10 latched by pin", ml[1] + mh[1], 0);
    chk(shut == 1'b1, "R10 latch state", int'(shut), 1);
    wr(4'h6, 8);
    check_period("R11 resumed after pin", 20, 10, 10, 10, 1);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule